// File: doc/BRIEF.md
# SPDIF Channel-Status and User-Data Sequencer

This block tracks where an SPDIF transmitter stands inside the 192-frame block. For every subframe it hands the serializer a payload made of the audio sample, the channel-status bit and the user bit for that subframe. It also raises a flag on the first subframe of each block, so that the serializer can pick the block preamble. Software or a DMA engine loads the block through a plain register write port. The port carries two 30-bit channel-status words, audio samples in channel-1-then-channel-2 order, and 32-bit user words. Audio and user data each pass through a two-stage buffer. A status flag shows when the first stage is free. A request line asks for fresh channel-status words once the programmable part of the current block has gone out.

The serializer side is a valid/ready stream, and each accepted transfer is one subframe. `sf_valid` is high in every cycle after reset leaves, because a payload is always on hand: when a buffer runs dry, the previous contents are sent again. While `sf_valid` is high and `sf_ready` is low, the whole payload holds still. The block position advances only on a cycle where both are high. The write port has no handshake. A write to a first stage that is already full is dropped.

Top module: `spdif_cs_user_seq`

## Requirements
- R1: The position moves through frames 0 to 191 and wraps to 0. Each frame is two subframes, channel 1 (`sf_chan`=0) and then channel 2 (`sf_chan`=1). The position advances only on a handshake. `sf_block_start` is high exactly on the channel-1 subframe of frame 0.
- R2: `sf_valid` is low during reset and high from the first clock after reset. While `sf_valid` is high and `sf_ready` is low, every payload output keeps its value into the next cycle.
- R3: In frames 0 to 29, `sf_cs_bit` is bit f of the active status word of the current channel, where f is the frame number, so bit 0 goes out first. In frames 30 to 191 it is 0.
- R4: A write to address 0 (channel 1) or address 1 (channel 2) stores `wr_data[29:0]` as a pending status word. Pending words become active on the handshake of the channel-2 subframe of frame 191. Until then the old active words keep being sent.
- R5: `cs_req` is set by the handshake of the channel-2 subframe of frame 29, so it is high once frame 30 is reached. A write to address 1 clears it. If both happen in the same cycle, setting wins.
- R6: A write to address 2 stores `wr_data[23:0]` as an audio sample. The first write after the first stage empties fills the channel-1 slot and the second fills the channel-2 slot. `aud_empty` is high when neither slot holds a sample. A third write, made while both slots are held, is dropped.
- R7: On the handshake of a channel-2 subframe, a full first stage moves into the output stage and `aud_empty` is set. If the first stage is not full, the output stage keeps the previous pair, and that pair is sent again.
- R8: A write to address 3 stores the 32-bit `wr_data` in the user first stage. `usr_empty` is high while that stage is empty. A write while it is full is dropped.
- R9: Each subframe carries one user bit, starting from bit 0 of the current word and going up one bit per handshake, across both channels in turn. After the handshake that sends bit 31, the next word is the first-stage word if one is held (this empties the stage). Otherwise the same word is sent again.
- R10: Reset produces frame 0, channel 1, all buffers and status words zero, `aud_empty` and `usr_empty` high, and `cs_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 status ch1, 1 status ch2, 2 audio, 3 user |
| wr_data | input | 32 | Write data |
| aud_empty | output | 1 | Audio first stage holds no sample |
| usr_empty | output | 1 | User first stage is empty |
| cs_req | output | 1 | Channel-status update request |
| sf_valid | output | 1 | Subframe payload valid |
| sf_ready | input | 1 | Serializer takes the subframe |
| sf_chan | output | 1 | 0 channel 1, 1 channel 2 |
| sf_block_start | output | 1 | First subframe of a block |
| sf_audio | output | 24 | Audio sample for this subframe |
| sf_cs_bit | output | 1 | Channel-status bit for this subframe |
| sf_user_bit | output | 1 | User bit for this subframe |

## Verification
The bench runs through several complete blocks with a serializer that stalls irregularly. A design that let the payload drift during a stall, or that advanced without a handshake, would put the status or user bits on the wrong frame. The bench writes status words in the early frames of a block. A design that made them active at once would show them mid-block, not at the next frame 0. It also starves the audio and user buffers. Here a design that shifted in zeros instead of resending the last pair or word would differ from the model. Writes to a full stage and status writes that land on the same cycle as the request edge check that a dropped write leaves no trace and that setting the request beats clearing it.

// File: rtl/spdif_seq_pkg.sv
package spdif_seq_pkg;
  // write-port address map; the status-word addresses double as channel index
  typedef enum logic [1:0] {
    WK_CS1 = 2'd0,
    WK_CS2 = 2'd1,
    WK_AUD = 2'd2,
    WK_USR = 2'd3
  } wr_kind_e;

  localparam int NCH = 2;
endpackage

// File: rtl/sdseq_frame_ctr.sv
module sdseq_frame_ctr #(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 30,
  localparam int FW     = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          req_clr,
  output logic [FW-1:0] frame,
  output logic          chan,
  output logic          wrap,
  output logic          cs_req
);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);
  localparam logic [FW-1:0] REQ_FRAME  = FW'(CS_BITS - 1);

  logic frame_end;
  logic req_set;

  assign frame_end = fire & chan;
  assign wrap      = frame_end & (frame == LAST_FRAME);
  assign req_set   = frame_end & (frame == REQ_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      chan  <= 1'b0;
    end else if (fire) begin
      chan <= ~chan;
      if (chan) frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cs_req <= 1'b0;
    else if (req_set) cs_req <= 1'b1;
    else if (req_clr) cs_req <= 1'b0;
  end
endmodule

// File: rtl/sdseq_cs_store.sv
module sdseq_cs_store
  import spdif_seq_pkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 30,
  localparam int FW     = $clog2(FRAMES),
  localparam int CIW    = $clog2(CS_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [CS_BITS-1:0] wr_word,
  input  logic               load,
  input  logic [FW-1:0]      frame,
  input  logic               chan,
  output logic               cs_bit
);
  logic [CS_BITS-1:0] act_w [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CS_BITS-1:0] pend_q;
    logic [CS_BITS-1:0] act_q;
    logic               hit;

    assign hit = wr_en & (wr_addr == 2'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (load) act_q  <= pend_q;
        if (hit)  pend_q <= wr_word;
      end
    end

    assign act_w[c] = act_q;
  end

  logic in_field;
  assign in_field = frame < FW'(CS_BITS);
  assign cs_bit   = in_field ? act_w[chan][frame[CIW-1:0]] : 1'b0;
endmodule

// File: rtl/sdseq_aud_dbuf.sv
module sdseq_aud_dbuf
  import spdif_seq_pkg::*;
#(
  parameter int AUD_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AUD_W-1:0] wr_sample,
  input  logic             advance,
  input  logic             chan,
  output logic [AUD_W-1:0] sample,
  output logic             empty
);
  logic [1:0] fill_q;
  logic       full;
  logic       take;
  logic       move;
  logic [AUD_W-1:0] out_w [NCH];

  assign full  = fill_q == 2'd2;
  assign empty = fill_q == 2'd0;
  assign take  = wr & ~full;
  assign move  = advance & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill_q <= '0;
    else if (move) fill_q <= '0;
    else if (take) fill_q <= fill_q + 2'd1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic [AUD_W-1:0] in_q;
    logic [AUD_W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        out_q <= '0;
      end else begin
        if (take && fill_q[0] == c[0]) in_q <= wr_sample;
        if (move) out_q <= in_q;
      end
    end

    assign out_w[c] = out_q;
  end

  assign sample = out_w[chan];
endmodule

// File: rtl/sdseq_usr_dbuf.sv
module sdseq_usr_dbuf #(
  parameter int USR_W = 32,
  localparam int IW   = $clog2(USR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [USR_W-1:0] wr_word,
  input  logic             advance,
  output logic             usr_bit,
  output logic             empty
);
  localparam logic [IW-1:0] LAST_BIT = IW'(USR_W - 1);

  logic [USR_W-1:0] in_q;
  logic [USR_W-1:0] cur_q;
  logic             full_q;
  logic [IW-1:0]    idx_q;
  logic             word_end;
  logic             take;
  logic             move;

  assign word_end = advance & (idx_q == LAST_BIT);
  assign take     = wr & ~full_q;
  assign move     = word_end & full_q;
  assign empty    = ~full_q;
  assign usr_bit  = cur_q[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      cur_q  <= '0;
      full_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (advance) idx_q <= word_end ? '0 : idx_q + 1'b1;
      if (move) begin
        cur_q  <= in_q;
        full_q <= 1'b0;
      end else if (take) begin
        in_q   <= wr_word;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spdif_cs_user_seq.sv
module spdif_cs_user_seq
  import spdif_seq_pkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 30,
  parameter int AUD_W   = 24,
  parameter int DATA_W  = 32,
  localparam int FW     = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              aud_empty,
  output logic              usr_empty,
  output logic              cs_req,
  output logic              sf_valid,
  input  logic              sf_ready,
  output logic              sf_chan,
  output logic              sf_block_start,
  output logic [AUD_W-1:0]  sf_audio,
  output logic              sf_cs_bit,
  output logic              sf_user_bit
);
  logic          fire;
  logic [FW-1:0] frame;
  logic          wrap;
  logic          cs2_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sf_valid <= 1'b0;
    else        sf_valid <= 1'b1;
  end

  assign fire   = sf_valid & sf_ready;
  assign cs2_wr = wr_en & (wr_addr == WK_CS2);

  sdseq_frame_ctr #(.FRAMES(FRAMES), .CS_BITS(CS_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .fire(fire), .req_clr(cs2_wr),
    .frame(frame), .chan(sf_chan), .wrap(wrap), .cs_req(cs_req)
  );

  sdseq_cs_store #(.FRAMES(FRAMES), .CS_BITS(CS_BITS)) u_cs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word(wr_data[CS_BITS-1:0]), .load(wrap), .frame(frame),
    .chan(sf_chan), .cs_bit(sf_cs_bit)
  );

  sdseq_aud_dbuf #(.AUD_W(AUD_W)) u_aud (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_addr == WK_AUD),
    .wr_sample(wr_data[AUD_W-1:0]), .advance(fire & sf_chan),
    .chan(sf_chan), .sample(sf_audio), .empty(aud_empty)
  );

  sdseq_usr_dbuf #(.USR_W(DATA_W)) u_usr (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_addr == WK_USR),
    .wr_word(wr_data), .advance(fire), .usr_bit(sf_user_bit),
    .empty(usr_empty)
  );

  assign sf_block_start = (frame == '0) & ~sf_chan;
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
  import spdif_seq_pkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CS_BITS = 30,
  parameter int AUD_W   = 24,
  localparam int FW     = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             sf_valid,
  input logic             sf_ready,
  input logic             sf_chan,
  input logic             sf_block_start,
  input logic [AUD_W-1:0] sf_audio,
  input logic             sf_cs_bit,
  input logic             sf_user_bit,
  input logic             aud_empty,
  input logic             usr_empty,
  input logic             cs_req,
  input logic [FW-1:0]    frame
);
  logic fire;
  assign fire = sf_valid & sf_ready;

  a_r1_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame < FW'(FRAMES));

  a_r1_block_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sf_block_start) |=> !sf_block_start);

  a_r2_valid_stays: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |=> sf_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && !sf_ready) |=> ($stable(sf_audio) && $stable(sf_chan) &&
      $stable(sf_cs_bit) && $stable(sf_user_bit) && $stable(sf_block_start)));

  a_r3_cs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame >= FW'(CS_BITS)) |-> !sf_cs_bit);

  a_r5_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_req) |-> $past(fire && sf_chan && frame == FW'(CS_BITS - 1)));

  a_r6_aud_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aud_empty) |-> $past(wr_en && wr_addr == WK_AUD));

  a_r7_aud_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aud_empty) |-> $past(fire && sf_chan));

  a_r8_usr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usr_empty) |-> $past(wr_en && wr_addr == WK_USR));
endmodule

bind spdif_cs_user_seq sdseq_chk #(
  .FRAMES(FRAMES), .CS_BITS(CS_BITS), .AUD_W(AUD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sf_valid(sf_valid), .sf_ready(sf_ready), .sf_chan(sf_chan),
  .sf_block_start(sf_block_start), .sf_audio(sf_audio),
  .sf_cs_bit(sf_cs_bit), .sf_user_bit(sf_user_bit),
  .aud_empty(aud_empty), .usr_empty(usr_empty), .cs_req(cs_req),
  .frame(frame)
);

// File: tb/sim_spdif_cs_user_seq.sv
module sim_spdif_cs_user_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        sf_ready = 1'b0;
  logic        aud_empty, usr_empty, cs_req, sf_valid, sf_chan;
  logic        sf_block_start, sf_cs_bit, sf_user_bit;
  logic [23:0] sf_audio;

  int vectors = 0;
  int fails = 0;
  bit started = 0;

  always #10 clk = ~clk;

  spdif_cs_user_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .aud_empty(aud_empty), .usr_empty(usr_empty),
    .cs_req(cs_req), .sf_valid(sf_valid), .sf_ready(sf_ready),
    .sf_chan(sf_chan), .sf_block_start(sf_block_start),
    .sf_audio(sf_audio), .sf_cs_bit(sf_cs_bit), .sf_user_bit(sf_user_bit)
  );

  // behavioural reference state
  int          m_frame = 0;
  int          m_ch = 0;
  bit          m_valid = 0;
  bit          m_req = 0;
  bit [29:0]   m_pend [2] = '{default: '0};
  bit [29:0]   m_act  [2] = '{default: '0};
  bit [23:0]   aq [$];
  bit [23:0]   a_cur [2] = '{default: '0};
  bit [31:0]   uq [$];
  bit [31:0]   u_cur = '0;
  int          u_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_frame = 0; m_ch = 0; m_valid = 0; m_req = 0;
      m_pend = '{default: '0}; m_act = '{default: '0};
      aq.delete(); a_cur = '{default: '0};
      uq.delete(); u_cur = '0; u_idx = 0;
    end else begin
      bit fire;
      int pre_a, pre_u;
      fire  = m_valid && sf_ready;
      pre_a = aq.size();
      pre_u = uq.size();
      // status words
      if (fire && m_ch == 1 && m_frame == 191) m_act = m_pend;
      if (wr_en && wr_addr == 2'd0) m_pend[0] = wr_data[29:0];
      if (wr_en && wr_addr == 2'd1) m_pend[1] = wr_data[29:0];
      if (fire && m_ch == 1 && m_frame == 29) m_req = 1;
      else if (wr_en && wr_addr == 2'd1) m_req = 0;
      // audio
      if (fire && m_ch == 1 && pre_a == 2) begin
        a_cur[0] = aq[0]; a_cur[1] = aq[1]; aq.delete();
      end
      if (wr_en && wr_addr == 2'd2 && pre_a < 2) aq.push_back(wr_data[23:0]);
      // user
      if (fire) begin
        if (u_idx == 31) begin
          if (pre_u == 1) u_cur = uq.pop_front();
          u_idx = 0;
        end else u_idx++;
      end
      if (wr_en && wr_addr == 2'd3 && pre_u == 0) uq.push_back(wr_data);
      // position
      if (fire) begin
        if (m_ch == 1) begin m_ch = 0; m_frame = (m_frame + 1) % 192; end
        else m_ch = 1;
      end
      m_valid = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int e_cs;
      e_cs = (m_frame < 30) ? int'(m_act[m_ch][m_frame]) : 0;
      chk("R2 sf_valid", int'(sf_valid), int'(m_valid));
      chk("R1 sf_chan", int'(sf_chan), m_ch);
      chk("R1 sf_block_start", int'(sf_block_start), int'(m_frame == 0 && m_ch == 0));
      chk("R3/R4 sf_cs_bit", int'(sf_cs_bit), e_cs);
      chk("R5 cs_req", int'(cs_req), int'(m_req));
      chk("R6/R7 sf_audio", int'(sf_audio), int'(a_cur[m_ch]));
      chk("R6 aud_empty", int'(aud_empty), int'(aq.size() == 0));
      chk("R9 sf_user_bit", int'(sf_user_bit), int'(u_cur[u_idx]));
      chk("R8 usr_empty", int'(usr_empty), int'(uq.size() == 0));
      if (!rst_n) chk("R10 reset frame", int'(sf_chan || !usr_empty || !aud_empty), 0);
    end
  end

  task automatic drive(int p_ready, int p_aud, int p_usr, int p_cs);
    @(posedge clk); #1;
    sf_ready = ($urandom_range(99) < p_ready);
    wr_en = 1'b0;
    wr_data = $urandom();
    if ($urandom_range(99) < p_cs) begin
      wr_en = 1'b1; wr_addr = 2'($urandom_range(1));
    end else if ($urandom_range(99) < p_aud) begin
      wr_en = 1'b1; wr_addr = 2'd2;
    end else if ($urandom_range(99) < p_usr) begin
      wr_en = 1'b1; wr_addr = 2'd3;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    started = 1;                        // R10 reset values compared here
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 1500; i++) drive(75, 30, 10, 3);  // mixed traffic
    for (int i = 0; i < 1000; i++) drive(75, 0, 0, 3);    // underrun: R7, R9
    for (int i = 0; i < 1500; i++) drive(100, 50, 20, 2); // full writes dropped
    for (int i = 0; i < 600; i++)  drive(20, 20, 10, 4);  // long stalls: R2
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule